// File: doc/BRIEF.md
# Sixteen-Bit Multicycle Register Processor

This block is a small processor that runs 16-bit instructions from an internal instruction store. It holds sixteen 16-bit general registers, a 256-word data store and an 8-bit program counter. Every instruction carries a 4-bit opcode in bits [15:12]. Six instructions are defined: constant load, register add, register subtract, direct-address load, direct-address store, and a jump relative to the program counter that depends on a register's value.

A state machine sequences the work. `ST_RESET` leads to `ST_FETCH`, which leads to `ST_DECODE`. `ST_DECODE` moves to one execute state (`ST_LOAD`, `ST_STORE`, `ST_ARITH`, `ST_CONST` or `ST_JUMP`). For an undefined opcode it moves straight back to `ST_FETCH`. Every execute state returns to `ST_FETCH`. A defined instruction therefore takes three cycles and an undefined one takes two.

The instruction store is filled through a write port while reset is held. Registers, data words and the program counter can be observed at any time through combinational debug read ports.

Top module: `tiny16_cpu`

## Requirements
- R1: While `rst` is high on a clock edge, the program counter returns to 0 and all sixteen registers return to 0. The first instruction fetched after reset comes from address 0, and `ST_RESET` moves to `ST_FETCH` on the next cycle.
- R2: Opcode 0011 writes the 8-bit field [7:0], zero-extended to 16 bits, into the register named by [11:8].
- R3: Opcode 0010 writes reg[[7:4]] + reg[[3:0]], modulo 2^16, into reg[[11:8]].
- R4: Opcode 0100 writes reg[[7:4]] − reg[[3:0]], modulo 2^16, into reg[[11:8]].
- R5: Opcode 0001 writes reg[[11:8]] into data word [7:0]. No register is written in the same cycle.
- R6: Opcode 0000 copies data word [7:0] into reg[[11:8]].
- R7: Opcode 1010 with reg[[11:8]] equal to zero sets the program counter to (jump address + 1 + sign-extended [7:0]) modulo 256. Offset 0xFF therefore repeats the jump forever.
- R8: Opcode 1010 with reg[[11:8]] non-zero continues at the jump address + 1.
- R9: Opcodes other than 0000, 0001, 0010, 0011, 0100 and 1010 change no register and no data word, and take two cycles.
- R10: `ST_FETCH` always moves to `ST_DECODE` and increments the program counter by one. Every execute state moves back to `ST_FETCH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | 8 | Instruction store write address |
| imem_wdata | input | 16 | Instruction word to write |
| dbg_reg_sel | input | 4 | Register index for the debug read |
| dbg_reg_data | output | 16 | Contents of the selected register |
| dbg_mem_addr | input | 8 | Data store address for the debug read |
| dbg_mem_data | output | 16 | Contents of the selected data word |
| dbg_pc | output | 8 | Current program counter |

## Verification
The assertions assume that the instruction store is written only while reset is held. A write while the machine runs could change the word being fetched, and the cycle-by-cycle checks on the program counter would then describe a program nobody intended. The assertions also assume that `rst` stays high for at least one full edge before execution starts.

The stimulus loads each program entirely inside a reset window. It then releases reset and only observes through the debug ports until the program parks on a self-targeting jump. The second program is loaded under a fresh reset, which also exercises clearing of the registers.

// File: rtl/tiny16_pkg.sv
package tiny16_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int REG_AW = 4;

    typedef enum logic [3:0] {
        OPC_LOAD  = 4'b0000,
        OPC_STORE = 4'b0001,
        OPC_ADD   = 4'b0010,
        OPC_CONST = 4'b0011,
        OPC_SUB   = 4'b0100,
        OPC_JUMP  = 4'b1010
    } opcode_e;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_FETCH,
        ST_DECODE,
        ST_LOAD,
        ST_STORE,
        ST_ARITH,
        ST_CONST,
        ST_JUMP
    } state_e;

endpackage

// File: rtl/tiny16_imem.sv
module tiny16_imem #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/tiny16_dmem.sv
module tiny16_dmem #(
    parameter int DW  = 16,
    parameter int AW  = 8,
    parameter int NRD = 2
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = words[raddr[g]];
    end

endmodule

// File: rtl/tiny16_regfile.sv
module tiny16_regfile #(
    parameter int DW  = 16,
    parameter int RAW = 4,
    parameter int NRD = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RAW-1:0] raddr [NRD],
    output logic [DW-1:0]  rdata [NRD]
);
    localparam int NREG = 1 << RAW;

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = regs[raddr[g]];
    end

endmodule

// File: rtl/tiny16_alu.sv
module tiny16_alu #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] y
);
    always_comb begin
        if (sub) begin
            y = a - b;
        end else begin
            y = a + b;
        end
    end

endmodule

// File: rtl/tiny16_cpu.sv
module tiny16_cpu
    import tiny16_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int RAW = REG_AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           imem_we,
    input  logic [AW-1:0]  imem_waddr,
    input  logic [DW-1:0]  imem_wdata,
    input  logic [RAW-1:0] dbg_reg_sel,
    output logic [DW-1:0]  dbg_reg_data,
    input  logic [AW-1:0]  dbg_mem_addr,
    output logic [DW-1:0]  dbg_mem_data,
    output logic [AW-1:0]  dbg_pc
);
    // Instruction field positions
    localparam int OPC_HI = DW - 1;
    localparam int OPC_LO = DW - 4;
    localparam int RD_LO  = OPC_LO - RAW;
    localparam int RA_LO  = RD_LO - RAW;
    localparam int RB_LO  = RA_LO - RAW;
    localparam int RF_RD  = 4;
    localparam int DM_RD  = 2;

    state_e state, state_nx;

    logic [AW-1:0] pc;
    logic [DW-1:0] ir;
    logic [DW-1:0] fetch_word;
    logic [3:0]    opc;

    logic          ir_load;
    logic          pc_jump;
    logic          rf_we;
    logic          dm_we;
    logic          alu_sub;
    logic [DW-1:0] wb_data;
    logic [DW-1:0] alu_y;
    logic          jreg_zero;

    logic [RAW-1:0] rf_raddr [RF_RD];
    logic [DW-1:0]  rf_rdata [RF_RD];
    logic [AW-1:0]  dm_raddr [DM_RD];
    logic [DW-1:0]  dm_rdata [DM_RD];

    assign opc = ir[OPC_HI:OPC_LO];

    // Storage
    tiny16_imem #(.DW(DW), .AW(AW)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .raddr (pc),
        .rdata (fetch_word)
    );

    // Read port 0: debug, 1: field [11:8], 2: field [7:4], 3: field [3:0]
    assign rf_raddr[0] = dbg_reg_sel;
    assign rf_raddr[1] = ir[RD_LO +: RAW];
    assign rf_raddr[2] = ir[RA_LO +: RAW];
    assign rf_raddr[3] = ir[RB_LO +: RAW];

    tiny16_regfile #(.DW(DW), .RAW(RAW), .NRD(RF_RD)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (ir[RD_LO +: RAW]),
        .wdata (wb_data),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    assign dm_raddr[0] = ir[AW-1:0];
    assign dm_raddr[1] = dbg_mem_addr;

    tiny16_dmem #(.DW(DW), .AW(AW), .NRD(DM_RD)) u_dm (
        .clk   (clk),
        .we    (dm_we),
        .waddr (ir[AW-1:0]),
        .wdata (rf_rdata[1]),
        .raddr (dm_raddr),
        .rdata (dm_rdata)
    );

    tiny16_alu #(.DW(DW)) u_alu (
        .a   (rf_rdata[2]),
        .b   (rf_rdata[3]),
        .sub (alu_sub),
        .y   (alu_y)
    );

    assign jreg_zero    = (rf_rdata[1] == '0);
    assign dbg_reg_data = rf_rdata[0];
    assign dbg_mem_data = dm_rdata[1];
    assign dbg_pc       = pc;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RESET;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = ST_FETCH;
        unique case (state)
            ST_RESET:  state_nx = ST_FETCH;
            ST_FETCH:  state_nx = ST_DECODE;
            ST_DECODE: begin
                case (opc)
                    OPC_LOAD:  state_nx = ST_LOAD;
                    OPC_STORE: state_nx = ST_STORE;
                    OPC_ADD:   state_nx = ST_ARITH;
                    OPC_SUB:   state_nx = ST_ARITH;
                    OPC_CONST: state_nx = ST_CONST;
                    OPC_JUMP:  state_nx = ST_JUMP;
                    default:   state_nx = ST_FETCH;
                endcase
            end
            ST_LOAD, ST_STORE, ST_ARITH, ST_CONST, ST_JUMP: state_nx = ST_FETCH;
        endcase
    end

    // Control outputs
    always_comb begin
        ir_load = 1'b0;
        pc_jump = 1'b0;
        rf_we   = 1'b0;
        dm_we   = 1'b0;
        alu_sub = (opc == OPC_SUB);
        wb_data = alu_y;
        unique case (state)
            ST_FETCH: ir_load = 1'b1;
            ST_LOAD: begin
                rf_we   = 1'b1;
                wb_data = dm_rdata[0];
            end
            ST_STORE: dm_we = 1'b1;
            ST_ARITH: rf_we = 1'b1;
            ST_CONST: begin
                rf_we   = 1'b1;
                wb_data = {{(DW-AW){1'b0}}, ir[AW-1:0]};
            end
            ST_JUMP:  pc_jump = jreg_zero;
            ST_RESET, ST_DECODE: ;
        endcase
    end

    // Program counter and instruction register
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            ir <= '0;
        end else if (ir_load) begin
            ir <= fetch_word;
            pc <= pc + AW'(1);
        end else if (pc_jump) begin
            // offset is as wide as the PC, so a modular add equals sign extension
            pc <= pc + ir[AW-1:0];
        end
    end

endmodule

// File: rtl/tiny16_cpu_chk.sv
module tiny16_cpu_chk
    import tiny16_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input state_e        state,
    input logic [AW-1:0] pc,
    input logic [3:0]    opc,
    input logic [AW-1:0] offset,
    input logic [DW-1:0] jreg,
    input logic          rf_we,
    input logic          dm_we
);
    logic defined_opc;
    assign defined_opc = (opc == OPC_LOAD) || (opc == OPC_STORE) || (opc == OPC_ADD) ||
                         (opc == OPC_CONST) || (opc == OPC_SUB) || (opc == OPC_JUMP);

    p_leave_reset_r1: assert property (@(posedge clk) disable iff (rst)
        state == ST_RESET |=> state == ST_FETCH);

    p_fetch_decode_r10: assert property (@(posedge clk) disable iff (rst)
        state == ST_FETCH |=> state == ST_DECODE);

    p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
        state == ST_FETCH |=> pc == $past(pc) + AW'(1));

    p_exec_back_r10: assert property (@(posedge clk) disable iff (rst)
        (state inside {ST_LOAD, ST_STORE, ST_ARITH, ST_CONST, ST_JUMP}) |=> state == ST_FETCH);

    p_undef_skip_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && !defined_opc) |=> state == ST_FETCH);

    p_jump_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_JUMP && jreg == '0) |=> pc == $past(pc) + $past(offset));

    p_jump_held_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_JUMP && jreg != '0) |=> $stable(pc));

    p_one_write_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_we, dm_we}));

endmodule

bind tiny16_cpu tiny16_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .state  (state),
    .pc     (pc),
    .opc    (opc),
    .offset (ir[AW-1:0]),
    .jreg   (rf_rdata[1]),
    .rf_we  (rf_we),
    .dm_we  (dm_we)
);

// File: tb/tiny16_cpu_test.sv
module tiny16_cpu_test;

    typedef struct {
        bit          is_mem;
        int          idx;
        logic [15:0] val;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_we = 1'b0;
    logic [7:0]  imem_waddr = '0;
    logic [15:0] imem_wdata = '0;
    logic [3:0]  dbg_reg_sel = '0;
    logic [15:0] dbg_reg_data;
    logic [7:0]  dbg_mem_addr = '0;
    logic [15:0] dbg_mem_data;
    logic [7:0]  dbg_pc;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    tiny16_cpu uut (
        .clk          (clk),
        .rst          (rst),
        .imem_we      (imem_we),
        .imem_waddr   (imem_waddr),
        .imem_wdata   (imem_wdata),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_data (dbg_reg_data),
        .dbg_mem_addr (dbg_mem_addr),
        .dbg_mem_data (dbg_mem_data),
        .dbg_pc       (dbg_pc)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: write an instruction word (reset must be held)
    task automatic put_word(input int addr, input logic [15:0] w);
        @(negedge clk);
        imem_we    = 1'b1;
        imem_waddr = addr[7:0];
        imem_wdata = w;
        @(negedge clk);
        imem_we    = 1'b0;
    endtask

    task automatic expect_reg(input int idx, input logic [15:0] v, input string req);
        sb.push_back('{1'b0, idx, v, req});
    endtask

    task automatic expect_mem(input int addr, input logic [15:0] v, input string req);
        sb.push_back('{1'b1, addr, v, req});
    endtask

    // Monitor: pop every expected item and compare through the debug ports
    task automatic drain();
        exp_t e;
        while (sb.size() > 0) begin
            e = sb.pop_front();
            @(negedge clk);
            if (e.is_mem) dbg_mem_addr = e.idx[7:0];
            else          dbg_reg_sel  = e.idx[3:0];
            #1;
            check(e.req, e.is_mem ? dbg_mem_data : dbg_reg_data, e.val);
        end
    endtask

    task automatic run_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        // ---- program A, loaded under reset ----
        put_word(0,  16'h3105); // CONST r1,05
        put_word(1,  16'h32F0); // CONST r2,F0
        put_word(2,  16'h2312); // ADD r3=r1+r2
        put_word(3,  16'h4412); // SUB r4=r1-r2
        put_word(4,  16'h2944); // ADD r9=r4+r4
        put_word(5,  16'h1340); // STORE r3 -> 40
        put_word(6,  16'h14FF); // STORE r4 -> FF
        put_word(7,  16'h0540); // LOAD r5 <- 40
        put_word(8,  16'h0AFF); // LOAD r10 <- FF
        put_word(9,  16'hA101); // JMP r1 (non-zero): falls through
        put_word(10, 16'h3611); // CONST r6,11
        put_word(11, 16'hA001); // JMP r0 (zero): to 13
        put_word(12, 16'h3722); // skipped
        put_word(13, 16'hF123); // undefined
        put_word(14, 16'h9BCD); // undefined
        put_word(15, 16'h5B00); // undefined
        put_word(16, 16'h3801); // CONST r8,01
        put_word(17, 16'hA0FF); // JMP r0,-1: parks at 17

        // R1: reset state
        @(negedge clk); #1;
        check("R1 pc", {8'h0, dbg_pc}, 16'h0000);
        for (int i = 0; i < 16; i++) expect_reg(i, 16'h0000, "R1 reg cleared");
        drain();

        @(negedge clk);
        rst = 1'b0;
        // R1: after RESET and FETCH the PC has stepped past address 0
        run_cycles(2); #1;
        check("R1 first fetch", {8'h0, dbg_pc}, 16'h0001);
        run_cycles(120);

        expect_reg(1,  16'h0005, "R2 const");
        expect_reg(2,  16'h00F0, "R2 zero-extend");
        expect_reg(3,  16'h00F5, "R3 add");
        expect_reg(4,  16'hFF15, "R4 sub wrap");
        expect_reg(9,  16'hFE2A, "R3 add wrap");
        expect_mem(8'h40, 16'h00F5, "R5 store");
        expect_mem(8'hFF, 16'hFF15, "R5 store top address");
        expect_reg(5,  16'h00F5, "R6 load");
        expect_reg(10, 16'hFF15, "R6 load top address");
        expect_reg(6,  16'h0011, "R8 not taken falls through");
        expect_reg(7,  16'h0000, "R7 taken skips");
        expect_reg(11, 16'h0000, "R9 undefined writes nothing");
        expect_reg(12, 16'h0000, "R9 undefined writes nothing");
        expect_reg(8,  16'h0001, "R9 resumes after undefined");
        drain();
        #1;
        n_checks++;
        if (!(dbg_pc == 8'd17 || dbg_pc == 8'd18)) begin
            n_fail++;
            $display("FAIL R7 park actual=%h expected=11 or 12", dbg_pc);
        end

        // ---- program B: countdown loop with backward jump ----
        @(negedge clk);
        rst = 1'b1;
        put_word(0, 16'h3103); // CONST r1,3
        put_word(1, 16'h3201); // CONST r2,1
        put_word(2, 16'h3407); // CONST r4,7
        put_word(3, 16'hA103); // JMP r1 zero -> 7
        put_word(4, 16'h2334); // ADD r3=r3+r4
        put_word(5, 16'h4112); // SUB r1=r1-r2
        put_word(6, 16'hA0FC); // JMP r0,-4 -> 3
        put_word(7, 16'hA0FF); // park
        @(negedge clk); #1;
        check("R1 pc after second reset", {8'h0, dbg_pc}, 16'h0000);
        expect_reg(3, 16'h0000, "R1 reg cleared by second reset");
        expect_reg(9, 16'h0000, "R1 reg cleared by second reset");
        drain();
        @(negedge clk);
        rst = 1'b0;
        run_cycles(150);
        expect_reg(3, 16'h0015, "R7 backward loop sum");
        expect_reg(1, 16'h0000, "R4 loop counter");
        drain();
        #1;
        n_checks++;
        if (!(dbg_pc == 8'd7 || dbg_pc == 8'd8)) begin
            n_fail++;
            $display("FAIL R7 park B actual=%h expected=07 or 08", dbg_pc);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule